// File: doc/BRIEF.md
# Asynchronous SRAM Bridge

This block connects a simple synchronous host port to an external asynchronous static RAM whose data bus is fixed at 16 bits. The host presents one request at a time: a byte address, a read/write flag, a size code (byte, halfword or word) and, for writes, the data. The bridge captures the request and runs it on the memory bus. A halfword becomes one memory access. A byte becomes one access with lane selection. A word becomes two back-to-back accesses, low halfword first.

Every memory access has the same shape. Chip select opens an address setup window of a programmable number of cycles with both strobes inactive. A data window follows in which output enable (reads) or write enable (writes) is low. Then comes a turnaround cycle with chip select released. Byte writes enable only the addressed lane. Reads always enable both lanes and extract the wanted byte internally. The memory data bus is split into an output word, an input word and an output-enable flag, so that a tristate pad can be placed outside the block.

Top module: `asram_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it: mem_cs_n, mem_oe_n and mem_we_n are 1, mem_be_n is 2'b11, mem_doe is 0 and host_ready is 0.
- R2: The memory word address is host_addr shifted right by one. The second access of a word request uses that address plus one. mem_addr is stable while chip select is low.
- R3: Size code 0 is a byte and 1 is a halfword; each makes one memory access. Codes 2 and 3 are a word and make two accesses.
- R4: Each access gives SETUP_CYC (3) cycles with mem_cs_n low and both strobes high. It then gives DATA_CYC (6) cycles with exactly one strobe low: mem_oe_n for a read, mem_we_n for a write. It ends with TURN_CYC (1) cycle with mem_cs_n high. The two strobes are never low together.
- R5: On a byte write, mem_dout carries the byte on both lanes. mem_be_n is 2'b10 when host_addr[0]=0 and 2'b01 when host_addr[0]=1, so the other byte of the word keeps its value. Halfword and word writes drive mem_be_n=2'b00, with the low halfword first (mem_dout = host_wdata[15:0], then [31:16]).
- R6: On every read, mem_be_n is 2'b00 whenever chip select is low. A byte read returns the byte selected by host_addr[0] (0 = bits 7:0 of the memory word) in host_rdata[7:0], with the upper bits zero. A halfword read returns the word in host_rdata[15:0], with the upper bits zero.
- R7: Read data is sampled on the last cycle of the data phase. A word read returns {second halfword, first halfword}.
- R8: mem_doe is 1 only during the data phase of a write.
- R9: host_ready is a one-cycle pulse in the cycle after the last turnaround, and host_rdata is valid in that cycle. A request is captured when it is accepted; changes on the host inputs have no effect until host_ready.
- R10: For halfword and word requests, host_addr[0] is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request present; accepted when the bridge is idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_addr | input | MEM_AW+1 | Byte address |
| host_wdata | input | 32 | Write data, little-endian |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ready |
| mem_addr | output | MEM_AW | Memory word address |
| mem_dout | output | 16 | Data toward the memory |
| mem_din | input | 16 | Data from the memory |
| mem_doe | output | 1 | Drive enable for mem_dout |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low (bit 0 = bits 7:0) |

## Verification
The hardest case to reach from the ports is showing that a byte write leaves its neighbour byte untouched, and that read data is taken in exactly the last data cycle. The bench memory model answers with the inverted word in every read cycle except the final data cycle, so a sample taken on any other edge returns wrong data. The bench sweeps every size over sixteen byte addresses. After each write it reads back at the same size and as an aligned word, which exposes any disturbance of the neighbour byte. While each request is running, the bench also scrambles the host inputs to show that only the captured request is carried out.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int MEM_DW  = 16;
    localparam int HOST_DW = 32;
    localparam int BYTE_W  = 8;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_DATA  = 3'd2,
        PH_TURN  = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    // Captured request control fields
    typedef struct packed {
        logic wr;      // write request
        logic wide;    // two halfword accesses
        logic narrow;  // single byte
        logic lane;    // byte lane of a narrow request
    } req_ctl_t;

    function automatic req_ctl_t decode_req(input logic wr,
                                            input logic [1:0] size,
                                            input logic lane0);
        req_ctl_t c;
        c.wr     = wr;
        c.wide   = size[1];
        c.narrow = (size == 2'd0);
        c.lane   = lane0 & (size == 2'd0);
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/asram_sequencer.sv
module asram_sequencer
    import asram_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int DATA_CYC  = 6,
    parameter int TURN_CYC  = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   two_beats,
    output phase_e phase,
    output logic   beat,
    output logic   capture
);
    localparam int CNT_W = $clog2(max3(SETUP_CYC, DATA_CYC, TURN_CYC) + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST  = CNT_W'(TURN_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            beat  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= '0;
                        beat  <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        phase <= PH_DATA;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt == DATA_LAST) begin
                        phase <= PH_TURN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_TURN: begin
                    if (cnt == TURN_LAST) begin
                        cnt <= '0;
                        if (!beat && two_beats) begin
                            beat  <= 1'b1;
                            phase <= PH_SETUP;
                        end else begin
                            phase <= PH_DONE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign capture = (phase == PH_DATA) && (cnt == DATA_LAST);

    // R4: the data window opens only after the full setup count
    assert_setup_before_data_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase) != PH_DATA) |->
        ($past(phase) == PH_SETUP && $past(cnt) == SETUP_LAST));

    // R3: a second setup window belongs to the second beat
    assert_second_beat_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETUP && $past(phase) == PH_TURN) |-> beat);

endmodule

// File: rtl/asram_lane_map.sv
module asram_lane_map
    import asram_pkg::*;
#(
    parameter int MEM_AW = 21
) (
    input  req_ctl_t             ctl,
    input  logic [MEM_AW-1:0]    base_word,
    input  logic [HOST_DW-1:0]   wdata,
    input  logic                 beat,
    output logic [MEM_AW-1:0]    addr,
    output logic [MEM_DW-1:0]    dout,
    output logic [MEM_DW/8-1:0]  be_wr_n
);
    logic [MEM_DW-1:0] half;

    always_comb begin
        addr = base_word + MEM_AW'(beat);
        half = beat ? wdata[HOST_DW-1:MEM_DW] : wdata[MEM_DW-1:0];
        if (ctl.narrow) begin
            dout    = {2{wdata[BYTE_W-1:0]}};
            be_wr_n = ctl.lane ? 2'b01 : 2'b10;
        end else begin
            dout    = half;
            be_wr_n = 2'b00;
        end
    end

endmodule

// File: rtl/asram_read_merge.sv
module asram_read_merge
    import asram_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic               beat,
    input  req_ctl_t           ctl,
    input  logic [MEM_DW-1:0]  din,
    output logic [HOST_DW-1:0] rdata
);
    logic [MEM_DW-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (capture) begin
            if (beat) hi_q <= din;
            else      lo_q <= din;
        end
    end

    always_comb begin
        if (ctl.wide)
            rdata = {hi_q, lo_q};
        else if (ctl.narrow)
            rdata = {{(HOST_DW-BYTE_W){1'b0}},
                     (ctl.lane ? lo_q[MEM_DW-1:BYTE_W] : lo_q[BYTE_W-1:0])};
        else
            rdata = {{(HOST_DW-MEM_DW){1'b0}}, lo_q};
    end

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
    import asram_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int DATA_CYC  = 6,
    parameter int TURN_CYC  = 1,
    parameter int MEM_AW    = 21,
    localparam int HOST_AW  = MEM_AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [1:0]         host_size,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic               host_ready,
    output logic [31:0]        host_rdata,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [15:0]        mem_dout,
    input  logic [15:0]        mem_din,
    output logic               mem_doe,
    output logic               mem_cs_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [1:0]         mem_be_n
);
    phase_e             phase;
    logic               beat;
    logic               capture;
    logic               accept;
    req_ctl_t           ctl_q;
    logic [MEM_AW-1:0]  base_q;
    logic [31:0]        wdata_q;
    logic [1:0]         be_wr_n;
    logic               in_access;
    logic               in_data;

    assign accept = host_req && (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            base_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            ctl_q   <= decode_req(host_we, host_size, host_addr[0]);
            base_q  <= host_addr[HOST_AW-1:1];
            wdata_q <= host_wdata;
        end
    end

    asram_sequencer #(
        .SETUP_CYC (SETUP_CYC),
        .DATA_CYC  (DATA_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .two_beats (ctl_q.wide),
        .phase     (phase),
        .beat      (beat),
        .capture   (capture)
    );

    asram_lane_map #(.MEM_AW(MEM_AW)) u_lanes (
        .ctl       (ctl_q),
        .base_word (base_q),
        .wdata     (wdata_q),
        .beat      (beat),
        .addr      (mem_addr),
        .dout      (mem_dout),
        .be_wr_n   (be_wr_n)
    );

    asram_read_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .capture (capture && !ctl_q.wr),
        .beat    (beat),
        .ctl     (ctl_q),
        .din     (mem_din),
        .rdata   (host_rdata)
    );

    assign in_access  = (phase == PH_SETUP) || (phase == PH_DATA);
    assign in_data    = (phase == PH_DATA);
    assign mem_cs_n   = !in_access;
    assign mem_oe_n   = !(in_data && !ctl_q.wr);
    assign mem_we_n   = !(in_data && ctl_q.wr);
    assign mem_doe    = in_data && ctl_q.wr;
    assign mem_be_n   = !in_access ? 2'b11 : (ctl_q.wr ? be_wr_n : 2'b00);
    assign host_ready = (phase == PH_DONE);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    assert_doe_write_R8: assert property (@(posedge clk) disable iff (rst)
        mem_doe |-> (!mem_we_n && !mem_cs_n));

    assert_read_lanes_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_be_n == 2'b00));

    assert_narrow_lane_R5: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && ctl_q.narrow) |-> ($countones(mem_be_n) == 1));

    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/asram_bridge_bench.sv
`timescale 1ns/1ps
module asram_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_size = 2'd0;
    logic [21:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic [20:0] mem_addr;
    logic [15:0] mem_dout;
    logic [15:0] mem_din = '0;
    logic        mem_doe, mem_cs_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_be_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] mdl [64];
    logic [7:0]  refb [128];

    always #4 clk = ~clk;

    asram_bridge u_asram_bridge (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_size(host_size), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_doe(mem_doe),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n)
    );

    task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Drive one request and check the memory-side waveform cycle by cycle
    task automatic run(input logic wr, input logic [1:0] sz, input logic [21:0] a,
                       input logic [31:0] wd, output logic [31:0] rd);
        int beats, total, e_time, e_addr, e_lane, e_rbe, e_doe, e_rdy, turns;
        logic [20:0] w0;
        beats = sz[1] ? 2 : 1;
        total = beats * 10;
        w0 = a[21:1];
        e_time = 0; e_addr = 0; e_lane = 0; e_rbe = 0; e_doe = 0; e_rdy = 0; turns = 0;
        rd = '0;
        @(negedge clk);
        host_req = 1; host_we = wr; host_size = sz; host_addr = a; host_wdata = wd;
        for (int k = 0; k <= total; k++) begin
            @(negedge clk);
            if (k == 0) begin
                host_addr = ~a; host_wdata = ~wd; host_size = ~sz; host_we = ~wr;
            end
            if (k < total) begin
                int b, j;
                logic data, turn;
                logic [1:0] ebe;
                logic [15:0] edo;
                b = k / 10; j = k % 10;
                data = (j >= 3) && (j < 9);
                turn = (j == 9);
                if (mem_cs_n !== turn || mem_oe_n !== !(data && !wr) ||
                    mem_we_n !== !(data && wr)) e_time++;
                if (turn && mem_cs_n === 1'b1) turns++;
                if (!turn && mem_addr !== 21'(w0 + 21'(b))) e_addr++;
                if (mem_doe !== (data && wr)) e_doe++;
                if (host_ready !== 1'b0) e_rdy++;
                if (!turn) begin
                    if (wr) begin
                        ebe = (sz == 2'd0) ? (a[0] ? 2'b01 : 2'b10) : 2'b00;
                        edo = (sz == 2'd0) ? {2{wd[7:0]}} : (b == 1 ? wd[31:16] : wd[15:0]);
                        if (mem_be_n !== ebe || (data && mem_dout !== edo)) e_lane++;
                    end else if (mem_be_n !== 2'b00) e_rbe++;
                end
                if (!mem_cs_n && !mem_we_n) begin
                    if (!mem_be_n[0]) mdl[mem_addr[5:0]][7:0]  = mem_dout[7:0];
                    if (!mem_be_n[1]) mdl[mem_addr[5:0]][15:8] = mem_dout[15:8];
                end
                mem_din = (data && j == 8 && !mem_oe_n) ? mdl[mem_addr[5:0]]
                                                        : ~mdl[mem_addr[5:0]];
            end else begin
                if (host_ready !== 1'b1) e_rdy++;
                rd = host_rdata;
                host_req = 0;
            end
        end
        chk(e_time == 0, "R4 phase timing mismatches", e_time, 0);
        chk(turns == beats, "R3 access count", turns, beats);
        if (a[0] && sz != 2'd0) chk(e_addr == 0, "R10 address ignores bit0", e_addr, 0);
        else                    chk(e_addr == 0, "R2 word address", e_addr, 0);
        chk(e_doe == 0, "R8 data drive enable", e_doe, 0);
        chk(e_rdy == 0, "R9 ready pulse timing", e_rdy, 0);
        if (wr) chk(e_lane == 0, "R5 write lanes/data", e_lane, 0);
        else    chk(e_rbe == 0, "R6 read lanes both low", e_rbe, 0);
    endtask

    task automatic do_write(input logic [1:0] sz, input logic [21:0] a, input logic [31:0] wd);
        logic [31:0] rd;
        logic [5:0] wi;
        run(1'b1, sz, a, wd, rd);
        wi = a[6:1];
        if (sz == 2'd0) refb[{wi, a[0]}] = wd[7:0];
        else begin
            refb[{wi, 1'b0}] = wd[7:0];
            refb[{wi, 1'b1}] = wd[15:8];
            if (sz[1]) begin
                refb[{wi + 6'd1, 1'b0}] = wd[23:16];
                refb[{wi + 6'd1, 1'b1}] = wd[31:24];
            end
        end
    endtask

    task automatic do_read(input logic [1:0] sz, input logic [21:0] a, input string tag);
        logic [31:0] rd, exp;
        logic [5:0] wi;
        run(1'b0, sz, a, 32'h0, rd);
        wi = a[6:1];
        if (sz == 2'd0)      exp = {24'h0, refb[{wi, a[0]}]};
        else if (sz == 2'd1) exp = {16'h0, refb[{wi, 1'b1}], refb[{wi, 1'b0}]};
        else exp = {refb[{wi + 6'd1, 1'b1}], refb[{wi + 6'd1, 1'b0}],
                    refb[{wi, 1'b1}], refb[{wi, 1'b0}]};
        chk(rd === exp, tag, rd, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        for (int i = 0; i < 128; i++) refb[i] = '0;
        repeat (3) @(negedge clk);
        chk({mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_doe, host_ready} === 7'b1111100,
            "R1 outputs during reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_doe, host_ready},
            7'b1111100);
        rst = 0;
        @(negedge clk);
        chk({mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_doe, host_ready} === 7'b1111100,
            "R1 outputs after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_doe, host_ready},
            7'b1111100);

        // Fill words 0..31 with a known pattern
        for (int w = 0; w < 32; w++)
            do_write(2'd1, 22'(w * 2), 32'(16'hA500 + w * 16'h0103));

        // Sweep sizes and byte addresses; read back at same size and as aligned word
        for (int sz = 0; sz < 3; sz++) begin
            for (int a = 0; a < 16; a++) begin
                logic [31:0] wd;
                wd = (32'h9E3779B9 * 32'(a + 1)) ^ (32'(sz) << 28);
                do_write(2'(sz), 22'(a), wd);
                if (sz == 2) do_read(2'(sz), 22'(a), "R7 word read-back");
                else         do_read(2'(sz), 22'(a), "R6 narrow read-back");
                do_read(2'd2, 22'(a & ~3), "R5 neighbour bytes intact (R7 word)");
            end
        end

        // Size code 3 behaves as a word
        do_write(2'd3, 22'd20, 32'hCAFE_1234);
        do_read(2'd2, 22'd20, "R3 size 3 written as word");
        do_read(2'd3, 22'd20, "R3 size 3 read as word");

        // Top of the address space
        do_write(2'd2, 22'h3FFFFC, 32'h0BAD_F00D);
        do_read(2'd2, 22'h3FFFFC, "R2 high address word");
        do_read(2'd0, 22'h3FFFFF, "R6 high address byte lane 1");

        report();
    end
endmodule